// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits in a processor's control path and decides, at each instruction boundary, whether a pending interrupt is taken. It watches one maskable request and one non-maskable request, keeps a global interrupt enable flag, and runs the full entry sequence when a request wins. The sequence covers the acknowledge handshake with the device, a push of the interrupted program counter onto a downward-growing memory stack, and a load of the handler address into the program counter.

The handler address comes from one of three places. Non-maskable entry always uses a fixed address. Maskable entry uses either a fixed address, or a base address plus four times a vector read from the device. A return command pops the saved frame, restores both the program counter and the enable flag, and so resumes the interrupted program. Frames nest, so a non-maskable interrupt may arrive inside a maskable handler.

While a sequence runs, `busy` tells the core to stall. The memory port has no wait states. A write completes at the clock edge that ends its request cycle. Read data is valid in the cycle after the read request.

Top module: `intr_sequencer`

## Requirements
- R1: After reset the unit is idle with `busy`, `irq_ack`, `nmi_ack`, `mem_req`, `pc_wr` and `int_en` all low, and `sp` equal to SP_TOP (default 16'hFF00).
- R2: While idle, `ei_cmd` sets `int_en` and `di_cmd` clears it, with `di_cmd` winning when both are high. Each takes effect at the next clock edge.
- R3: A maskable request at a boundary while `int_en` is low is ignored. There is no acknowledge, no memory access and no program counter write, and `busy` stays low.
- R4: Requests and the return command are only acted on in a cycle where `insn_boundary` is high. With it low, the unit stays idle.
- R5: A non-maskable request at a boundary is taken whatever the value of `int_en`, and it wins over a simultaneous maskable request. Only `nmi_ack` is raised.
- R6: The acknowledge for the winning source rises in the cycle after the boundary. It stays high for as long as that request stays high, and it falls in the cycle after the request is first seen low.
- R7: In the cycle the acknowledge falls, the unit issues one write to address `sp-1`. The data has the interrupted program counter in bits PCW-1:0 and the pre-entry `int_en` in bit PCW. `sp` is decremented at the same edge.
- R8: In the cycle after the push, `pc_wr` is high for one cycle. For non-maskable entry `pc_wr_data` is NMI_ADDR (16'h0020). For maskable entry with `vec_mode` low at the boundary, it is IRQ_ADDR (16'h0040).
- R9: For maskable entry with `vec_mode` high at the boundary, `vec_in` is captured in the cycle the request is first seen low, and the handler address is VEC_BASE + 4*vector (VEC_BASE = 16'h0100).
- R10: `int_en` is low from the edge that ends the push until it is changed by a command or a return.
- R11: A return command at a boundary where no interrupt is taken issues a read at `sp` and increments `sp`. In the next cycle it writes the word's low PCW bits to the program counter and copies bit PCW into `int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | High in a cycle where an instruction has completed |
| ei_cmd | input | 1 | Set the interrupt enable flag |
| di_cmd | input | 1 | Clear the interrupt enable flag |
| rti_cmd | input | 1 | Return from interrupt |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| vec_mode | input | 1 | Maskable entry uses the device vector when high |
| vec_in | input | VW | Vector from the requesting device |
| pc_cur | input | PCW | Current program counter |
| irq_ack | output | 1 | Maskable acknowledge |
| nmi_ack | output | 1 | Non-maskable acknowledge |
| busy | output | 1 | Sequence in progress; core must stall |
| int_en | output | 1 | Global interrupt enable flag |
| pc_wr | output | 1 | Program counter load strobe |
| pc_wr_data | output | PCW | Value to load into the program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | PCW+1 | Stack frame to write |
| mem_rdata | input | PCW+1 | Stack frame read, valid the cycle after a read |
| sp | output | AW | Stack pointer |

## Verification
Entry is tried four ways:
- maskable nonvectored;
- maskable vectored with a small vector;
- maskable vectored with the all-ones vector, which shows whether the shift and add keep the top vector bits;
- non-maskable with the enable flag off and a maskable request raised at the same time, which separates priority from masking.

A held request with no boundary, and a request while the flag is clear, must both leave the port quiet. A nested sequence takes a maskable entry, then a non-maskable entry inside it, then two returns. This tells whether frames unwind last-in-first-out and whether the saved flag, not the current one, comes back. Every memory access and program counter load is compared in order against a queue of expected events, so a load issued before its push is caught.

// File: rtl/intr_sequencer.sv
module intr_sequencer #(
  parameter int PCW = 16,
  parameter int AW = 16,
  parameter int VW = 8,
  parameter logic [AW-1:0] SP_TOP = 16'hFF00,
  parameter logic [PCW-1:0] IRQ_ADDR = 16'h0040,
  parameter logic [PCW-1:0] NMI_ADDR = 16'h0020,
  parameter logic [PCW-1:0] VEC_BASE = 16'h0100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           insn_boundary,
  input  logic           ei_cmd,
  input  logic           di_cmd,
  input  logic           rti_cmd,
  input  logic           irq_req,
  input  logic           nmi_req,
  input  logic           vec_mode,
  input  logic [VW-1:0]  vec_in,
  input  logic [PCW-1:0] pc_cur,
  output logic           irq_ack,
  output logic           nmi_ack,
  output logic           busy,
  output logic           int_en,
  output logic           pc_wr,
  output logic [PCW-1:0] pc_wr_data,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [PCW:0]   mem_wdata,
  input  logic [PCW:0]   mem_rdata,
  output logic [AW-1:0]  sp
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK, ST_PUSH, ST_JUMP, ST_POP, ST_LOAD
  } state_t;

  state_t         st;
  logic [AW-1:0]  sp_q;
  logic           ie_q;
  logic           from_nmi;
  logic           vmode_q;
  logic [VW-1:0]  vec_q;
  logic [PCW-1:0] pc_q;

  logic idle, take_nmi, take_irq, take_rti, req_live;
  logic [PCW-1:0] vec_addr, target;

  assign idle     = (st == ST_IDLE);
  assign take_nmi = idle && insn_boundary && nmi_req;
  assign take_irq = idle && insn_boundary && !nmi_req && irq_req && ie_q;
  assign take_rti = idle && insn_boundary && !take_nmi && !take_irq && rti_cmd;
  assign req_live = from_nmi ? nmi_req : irq_req;

  assign vec_addr = VEC_BASE + (PCW'(vec_q) << 2);
  assign target   = from_nmi ? NMI_ADDR : (vmode_q ? vec_addr : IRQ_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sp_q     <= SP_TOP;
      ie_q     <= 1'b0;
      from_nmi <= 1'b0;
      vmode_q  <= 1'b0;
      vec_q    <= '0;
      pc_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (di_cmd)      ie_q <= 1'b0;
          else if (ei_cmd) ie_q <= 1'b1;
          if (take_nmi || take_irq) begin
            st       <= ST_ACK;
            from_nmi <= take_nmi;
            vmode_q  <= vec_mode;
            pc_q     <= pc_cur;
          end else if (take_rti) begin
            st <= ST_POP;
          end
        end
        ST_ACK: begin
          if (!req_live) begin
            vec_q <= vec_in;
            st    <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          sp_q <= sp_q - AW'(1);
          ie_q <= 1'b0;
          st   <= ST_JUMP;
        end
        ST_JUMP: st <= ST_IDLE;
        ST_POP: begin
          sp_q <= sp_q + AW'(1);
          st   <= ST_LOAD;
        end
        ST_LOAD: begin
          ie_q <= mem_rdata[PCW];
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = !idle;
  assign int_en     = ie_q;
  assign sp         = sp_q;
  assign irq_ack    = (st == ST_ACK) && !from_nmi;
  assign nmi_ack    = (st == ST_ACK) && from_nmi;
  assign mem_req    = (st == ST_PUSH) || (st == ST_POP);
  assign mem_we     = (st == ST_PUSH);
  assign mem_addr   = (st == ST_POP) ? sp_q : sp_q - AW'(1);
  assign mem_wdata  = {ie_q, pc_q};
  assign pc_wr      = (st == ST_JUMP) || (st == ST_LOAD);
  assign pc_wr_data = (st == ST_LOAD) ? mem_rdata[PCW-1:0] : target;

endmodule

// File: rtl/intr_sequencer_chk.sv
module intr_sequencer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_boundary,
  input logic          rti_cmd,
  input logic          irq_req,
  input logic          nmi_req,
  input logic          busy,
  input logic          int_en,
  input logic          irq_ack,
  input logic          nmi_ack,
  input logic          mem_req,
  input logic          mem_we,
  input logic          pc_wr,
  input logic [AW-1:0] sp
);

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && insn_boundary && irq_req && !nmi_req && !int_en && !rti_cmd)
    |=> (!irq_ack && !mem_req && !busy)); // R3

  AST_NO_BOUNDARY_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_boundary) |=> !busy); // R4

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && insn_boundary && nmi_req) |=> (nmi_ack && !irq_ack)); // R5

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, nmi_ack})); // R6

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> irq_ack); // R6

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp == $past(sp) - AW'(1))); // R7

  AST_LOAD_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> pc_wr); // R8

  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !int_en); // R10

  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (pc_wr && sp == $past(sp) + AW'(1))); // R11

endmodule

bind intr_sequencer intr_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .rti_cmd(rti_cmd),
  .irq_req(irq_req), .nmi_req(nmi_req), .busy(busy), .int_en(int_en),
  .irq_ack(irq_ack), .nmi_ack(nmi_ack), .mem_req(mem_req), .mem_we(mem_we),
  .pc_wr(pc_wr), .sp(sp)
);

// File: tb/intr_sequencer_test.sv
`timescale 1ns/1ps
module intr_sequencer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic insn_boundary = 0, ei_cmd = 0, di_cmd = 0, rti_cmd = 0;
  logic irq_req = 0, nmi_req = 0, vec_mode = 0;
  logic [7:0]  vec_in = '0;
  logic [15:0] pc_cur = '0;
  logic irq_ack, nmi_ack, busy, int_en, pc_wr, mem_req, mem_we;
  logic [15:0] pc_wr_data, mem_addr, sp;
  logic [16:0] mem_wdata, mem_rdata = '0;
  logic [16:0] mem [256];

  int tests = 0, fails = 0;
  logic [34:0] expq[$];
  logic [15:0] sp_exp = 16'hFF00;
  logic ie_exp = 1'b0;

  always #5 clk = ~clk;

  intr_sequencer uut (.*);

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares each memory access and PC load against the queue
  always @(negedge clk) begin
    if (rst_n && (mem_req || pc_wr)) begin
      logic [34:0] got, exp;
      if (mem_req) got = {mem_we ? 2'd0 : 2'd2, mem_addr, mem_we ? mem_wdata : 17'd0};
      else         got = {2'd1, 16'h0, 1'b0, pc_wr_data};
      tests++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R3/R7/R8/R11 unexpected event: got %h expected none", got);
      end else begin
        exp = expq.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL R7/R8/R9/R11 event: got %h expected %h", got, exp);
        end
      end
    end
  end

  task automatic take(bit nmi, bit also_irq, bit vm, logic [7:0] v,
                      logic [15:0] pc, logic [15:0] tgt);
    @(negedge clk);
    expq.push_back({2'd0, sp_exp - 16'd1, ie_exp, pc});
    expq.push_back({2'd1, 16'h0, 1'b0, tgt});
    insn_boundary = 1; pc_cur = pc; vec_mode = vm;
    nmi_req = nmi; irq_req = !nmi || also_irq;
    @(negedge clk);
    insn_boundary = 0;
    chk("R6 ack rise", {irq_ack, nmi_ack}, nmi ? 2'b01 : 2'b10);
    @(negedge clk);
    chk("R6 ack held", {irq_ack, nmi_ack}, nmi ? 2'b01 : 2'b10);
    if (nmi) nmi_req = 0; else irq_req = 0;
    vec_in = v;
    @(negedge clk);
    vec_in = ~v;
    chk("R6 ack fall", {irq_ack, nmi_ack}, 2'b00);
    @(negedge clk);
    @(negedge clk);
    irq_req = 0;
    sp_exp = sp_exp - 16'd1;
    ie_exp = 0;
    chk("R10 flag cleared", int_en, 0);
    chk("R7 sp after push", sp, sp_exp);
    chk("R8 idle after entry", busy, 0);
  endtask

  task automatic ret(logic [15:0] pc, logic ie);
    @(negedge clk);
    expq.push_back({2'd2, sp_exp, 17'd0});
    expq.push_back({2'd1, 16'h0, 1'b0, pc});
    insn_boundary = 1; rti_cmd = 1;
    @(negedge clk);
    insn_boundary = 0; rti_cmd = 0;
    @(negedge clk);
    @(negedge clk);
    sp_exp = sp_exp + 16'd1;
    ie_exp = ie;
    chk("R11 flag restored", int_en, ie);
    chk("R11 sp after pop", sp, sp_exp);
  endtask

  task automatic set_ie(bit e, bit d, bit exp);
    @(negedge clk);
    ei_cmd = e; di_cmd = d;
    @(negedge clk);
    ei_cmd = 0; di_cmd = 0;
    ie_exp = exp;
    chk("R2 enable flag", int_en, exp);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {busy, irq_ack, nmi_ack, mem_req, pc_wr, int_en}, 0);
    chk("R1 reset sp", sp, 16'hFF00);

    // R3: masked request ignored
    irq_req = 1; insn_boundary = 1;
    @(negedge clk);
    insn_boundary = 0;
    chk("R3 no ack while masked", {irq_ack, busy}, 0);
    @(negedge clk);
    chk("R3 still idle", busy, 0);
    irq_req = 0;

    set_ie(1, 1, 0);   // R2 di wins
    set_ie(1, 0, 1);   // R2 ei

    // R4: request held without a boundary
    irq_req = 1;
    repeat (3) @(negedge clk);
    chk("R4 no boundary no entry", {busy, irq_ack}, 0);
    irq_req = 0;

    take(0, 0, 0, 8'h33, 16'h1234, 16'h0040);      // R8 nonvectored
    ret(16'h1234, 1);
    take(0, 0, 1, 8'h05, 16'h2000, 16'h0114);      // R9 vectored
    ret(16'h2000, 1);
    take(0, 0, 1, 8'hFF, 16'h3000, 16'h04FC);      // R9 all-ones vector
    ret(16'h3000, 1);

    set_ie(0, 1, 0);
    take(1, 1, 1, 8'h07, 16'h4321, 16'h0020);      // R5 nmi with flag off
    ret(16'h4321, 0);

    set_ie(1, 0, 1);
    take(0, 0, 0, 8'h00, 16'h0AAA, 16'h0040);      // R11 nested
    take(1, 0, 0, 8'h00, 16'h0045, 16'h0020);
    ret(16'h0045, 0);
    ret(16'h0AAA, 1);

    repeat (3) @(negedge clk);
    chk("R11 queue drained", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule